// File: doc/BRIEF.md
# Dual-Mode Signed Multiplier Slice

This block is a pipelined arithmetic slice for filter and transform datapaths. A static configuration input picks one of two precisions. In narrow precision the slice holds two signed multipliers. Each multiplies an 18-bit operand by a 19-bit operand. The two 37-bit products can leave the slice side by side, or they can be combined into one sum or difference. In wide precision the same slice forms one signed 27x27 product.

The first operand of each multiplier comes from one of two places. It can be the external input, or it can be one entry of a small coefficient store inside the slice. A 3-bit select picks the entry, and that select may change on every cycle. This lets one slice step through a short set of filter taps without any memory outside it. The store has two banks of eight entries. Bank 0 is 27 bits wide and serves multiplier 0, and also serves the wide multiplier. Bank 1 is 18 bits wide and serves multiplier 1. Entries are loaded through an addressed write port. Every mode has the same fixed pipeline depth, and a valid flag moves along with the data.

Top module: `dmul_slice`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` is 0, and every coefficient entry in both banks reads as zero.
- R2: With `cfg_wide`=0 and `cfg_sum`=0, `out_data[36:0]` holds the signed product of `opx0[17:0]` and `opy0[18:0]`. `out_data[73:37]` holds the signed product of `opx1` and `opy1`.
- R3: With `cfg_wide`=1, `out_data` holds the signed 54-bit product of `opx0` and `opy0`, sign-extended to 74 bits.
- R4: With `cfg_wide`=0, `cfg_sum`=1 and `cfg_sub`=0, `out_data` holds the sum of the two narrow products, sign-extended to 74 bits.
- R5: With `cfg_wide`=0, `cfg_sum`=1 and `cfg_sub`=1, `out_data` holds product 0 minus product 1, sign-extended to 74 bits.
- R6: In narrow mode, setting `coef_use0` replaces `opx0[17:0]` with the low 18 bits of bank-0 entry `coef_sel0`. Setting `coef_use1` replaces `opx1` with bank-1 entry `coef_sel1`.
- R7: In wide mode, setting `coef_use0` replaces `opx0` with the full 27-bit bank-0 entry `coef_sel0`.
- R8: A sample taken with `in_valid`=1 produces its result, with `out_valid`=1, exactly two clock edges later. `out_valid` is 0 for every other cycle.
- R9: A write to the coefficient store takes effect on the following cycle. A select of the same entry in the same cycle as the write still sees the old value.
- R10: The coefficient select may change on every cycle. Back-to-back samples that select different entries each use their own entry.
- R11: `out_data` keeps its last value while `out_valid` is 0.
- R12: A write with `cw_bank`=1 stores only `cw_data[17:0]`, and only into entry `cw_addr` of bank 1. A write with `cw_bank`=0 stores all 27 bits, and only into entry `cw_addr` of bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1: one 27x27 multiplier; 0: two 18x19 multipliers |
| cfg_sum | input | 1 | Narrow mode: 1 combines the two products, 0 keeps them separate |
| cfg_sub | input | 1 | When combining: 1 subtracts product 1 from product 0 |
| in_valid | input | 1 | Sample valid |
| opx0 | input | 27 | First operand of multiplier 0 (low 18 bits in narrow mode) |
| opy0 | input | 27 | Second operand of multiplier 0 (low 19 bits in narrow mode) |
| opx1 | input | 18 | First operand of multiplier 1 |
| opy1 | input | 19 | Second operand of multiplier 1 |
| coef_use0 | input | 1 | Take multiplier 0's first operand from bank 0 |
| coef_use1 | input | 1 | Take multiplier 1's first operand from bank 1 |
| coef_sel0 | input | 3 | Bank-0 entry select |
| coef_sel1 | input | 3 | Bank-1 entry select |
| cw_en | input | 1 | Coefficient write enable |
| cw_bank | input | 1 | Bank written (0 or 1) |
| cw_addr | input | 3 | Entry written |
| cw_data | input | 27 | Coefficient write data |
| out_valid | output | 1 | Result valid |
| out_data | output | 74 | Registered result |

## Verification
The bench pushes the most negative operand pairs through every mode. This exposes a slice that sign-extends the sum or the wide product from the wrong bit, or that treats an operand as unsigned. Those faults would show up as large positive values or as garbage in the upper bits. A write followed at once by a read of the same entry checks the one-cycle visibility rule. A design that bypassed the write data, or that delayed it one cycle too long, would return the new or the old coefficient at the wrong time. Selects that change on every cycle catch a select that is sampled late. Writes to bank 1 with nonzero upper data bits catch a store that keeps bits it should drop, or that writes into the neighbouring entries. Idle gaps between bursts catch an output register that reloads without a valid sample behind it.

// File: rtl/dmul_pkg.sv
`timescale 1ns/1ps
package dmul_pkg;

    // Result formatting selected per sample in the first pipeline stage
    typedef enum logic [1:0] {
        FMT_SPLIT = 2'd0,
        FMT_SUM   = 2'd1,
        FMT_DIFF  = 2'd2,
        FMT_WIDE  = 2'd3
    } fmt_e;

endpackage

// File: rtl/dmul_coef_bank.sv
`timescale 1ns/1ps
module dmul_coef_bank #(
    parameter int NENT = 8,
    parameter int WW   = 27,
    parameter int NW   = 18,
    localparam int AW  = $clog2(NENT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [WW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr0,
    input  logic [AW-1:0] rd_addr1,
    output logic [WW-1:0] rd_data0,
    output logic [NW-1:0] rd_data1
);

    typedef struct packed {
        logic [NENT-1:0][WW-1:0] wide_bank;
        logic [NENT-1:0][NW-1:0] narrow_bank;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NENT; i++) begin
            if (wr_en && !wr_bank && wr_addr == AW'(i))
                st_d.wide_bank[i] = wr_data;
            if (wr_en && wr_bank && wr_addr == AW'(i))
                st_d.narrow_bank[i] = wr_data[NW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Reads come from the registered store, so a write shows up the next cycle
    assign rd_data0 = st_q.wide_bank[rd_addr0];
    assign rd_data1 = st_q.narrow_bank[rd_addr1];

endmodule

// File: rtl/dmul_product.sv
`timescale 1ns/1ps
module dmul_product
    import dmul_pkg::*;
#(
    parameter int NA    = 18,
    parameter int NB    = 19,
    parameter int WIDE  = 27,
    parameter int OUT_W = 74,
    localparam int PN   = NA + NB,
    localparam int PW   = 2 * WIDE
) (
    input  fmt_e             fmt,
    input  logic [WIDE-1:0]  xa,
    input  logic [WIDE-1:0]  ya,
    input  logic [NA-1:0]    xb,
    input  logic [NB-1:0]    yb,
    output logic [OUT_W-1:0] res
);

    logic [1:0][NA-1:0] lane_x;
    logic [1:0][NB-1:0] lane_y;
    logic [1:0][PN-1:0] lane_p;
    logic [PN:0]        comb_s;
    logic [PW-1:0]      wide_p;

    assign lane_x[0] = xa[NA-1:0];
    assign lane_y[0] = ya[NB-1:0];
    assign lane_x[1] = xb;
    assign lane_y[1] = yb;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign lane_p[g] = $signed(lane_x[g]) * $signed(lane_y[g]);
    end

    assign wide_p = $signed(xa) * $signed(ya);

    always_comb begin
        if (fmt == FMT_DIFF)
            comb_s = {lane_p[0][PN-1], lane_p[0]} - {lane_p[1][PN-1], lane_p[1]};
        else
            comb_s = {lane_p[0][PN-1], lane_p[0]} + {lane_p[1][PN-1], lane_p[1]};
    end

    always_comb begin
        res = '0;
        unique case (fmt)
            FMT_SPLIT: begin
                res[PN-1:0]    = lane_p[0];
                res[2*PN-1:PN] = lane_p[1];
            end
            FMT_SUM, FMT_DIFF: res = {{(OUT_W-PN-1){comb_s[PN]}}, comb_s};
            FMT_WIDE:          res = {{(OUT_W-PW){wide_p[PW-1]}}, wide_p};
            default:           res = '0;
        endcase
    end

endmodule

// File: rtl/dmul_slice.sv
`timescale 1ns/1ps
module dmul_slice
    import dmul_pkg::*;
#(
    parameter int NA    = 18,
    parameter int NB    = 19,
    parameter int WIDE  = 27,
    parameter int NCOEF = 8,
    parameter int OUT_W = 74,
    localparam int SELW = $clog2(NCOEF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wide,
    input  logic             cfg_sum,
    input  logic             cfg_sub,
    input  logic             in_valid,
    input  logic [WIDE-1:0]  opx0,
    input  logic [WIDE-1:0]  opy0,
    input  logic [NA-1:0]    opx1,
    input  logic [NB-1:0]    opy1,
    input  logic             coef_use0,
    input  logic             coef_use1,
    input  logic [SELW-1:0]  coef_sel0,
    input  logic [SELW-1:0]  coef_sel1,
    input  logic             cw_en,
    input  logic             cw_bank,
    input  logic [SELW-1:0]  cw_addr,
    input  logic [WIDE-1:0]  cw_data,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);

    typedef struct packed {
        logic            vld;
        fmt_e            fmt;
        logic [WIDE-1:0] xa;
        logic [WIDE-1:0] ya;
        logic [NA-1:0]   xb;
        logic [NB-1:0]   yb;
    } in_stage_t;

    typedef struct packed {
        in_stage_t        s1;
        logic             vld;
        logic [OUT_W-1:0] data;
    } pipe_t;

    pipe_t            st_d, st_q;
    logic [WIDE-1:0]  coef0_rd;
    logic [NA-1:0]    coef1_rd;
    logic [OUT_W-1:0] prod_res;

    dmul_coef_bank #(
        .NENT (NCOEF),
        .WW   (WIDE),
        .NW   (NA)
    ) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cw_en),
        .wr_bank  (cw_bank),
        .wr_addr  (cw_addr),
        .wr_data  (cw_data),
        .rd_addr0 (coef_sel0),
        .rd_addr1 (coef_sel1),
        .rd_data0 (coef0_rd),
        .rd_data1 (coef1_rd)
    );

    dmul_product #(
        .NA    (NA),
        .NB    (NB),
        .WIDE  (WIDE),
        .OUT_W (OUT_W)
    ) prod_i (
        .fmt (st_q.s1.fmt),
        .xa  (st_q.s1.xa),
        .ya  (st_q.s1.ya),
        .xb  (st_q.s1.xb),
        .yb  (st_q.s1.yb),
        .res (prod_res)
    );

    always_comb begin
        st_d        = st_q;
        // stage 1: operand capture with coefficient substitution
        st_d.s1.vld = in_valid;
        if (in_valid) begin
            if (cfg_wide)     st_d.s1.fmt = FMT_WIDE;
            else if (!cfg_sum) st_d.s1.fmt = FMT_SPLIT;
            else if (cfg_sub)  st_d.s1.fmt = FMT_DIFF;
            else               st_d.s1.fmt = FMT_SUM;
            st_d.s1.xa = coef_use0 ? coef0_rd : opx0;
            st_d.s1.ya = opy0;
            st_d.s1.xb = coef_use1 ? coef1_rd : opx1;
            st_d.s1.yb = opy1;
        end
        // stage 2: result register, loaded only behind a valid sample
        st_d.vld = st_q.s1.vld;
        if (st_q.s1.vld) st_d.data = prod_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;

endmodule

// File: rtl/dmul_slice_chk.sv
`timescale 1ns/1ps
module dmul_slice_chk #(
    parameter int NA    = 18,
    parameter int NB    = 19,
    parameter int WIDE  = 27,
    parameter int OUT_W = 74
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wide,
    input logic             cfg_sum,
    input logic             in_valid,
    input logic [WIDE-1:0]  opx0,
    input logic [WIDE-1:0]  opy0,
    input logic             coef_use0,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data
);

    localparam int PN = NA + NB;
    localparam int PW = 2 * WIDE;

    logic [1:0]    since_rst;
    logic [PN-1:0] ref_lo;
    logic          split_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assign ref_lo    = $signed(opx0[NA-1:0]) * $signed(opy0[NB-1:0]);
    assign split_raw = in_valid && !cfg_wide && !cfg_sum && !coef_use0;

    // R8: valid emerges exactly two edges after it was presented
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst >= 2'd2 |-> out_valid == $past(in_valid, 2));

    // R11: no reload without a valid sample
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && !out_valid) |-> $stable(out_data));

    // R3: wide result upper bits are a pure sign extension
    p_wide_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && out_valid && $past(cfg_wide && in_valid, 2)) |->
        (out_data[OUT_W-1:PW-1] == '0 || out_data[OUT_W-1:PW-1] == '1));

    // R4: combined narrow result upper bits are a pure sign extension
    p_sum_sext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && out_valid && $past(in_valid && !cfg_wide && cfg_sum, 2)) |->
        (out_data[OUT_W-1:PN] == '0 || out_data[OUT_W-1:PN] == '1));

    // R2: low lane equals the external-operand product
    p_split_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && out_valid && $past(split_raw, 2)) |->
        out_data[PN-1:0] == $past(ref_lo, 2));

endmodule

bind dmul_slice dmul_slice_chk #(
    .NA    (NA),
    .NB    (NB),
    .WIDE  (WIDE),
    .OUT_W (OUT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wide  (cfg_wide),
    .cfg_sum   (cfg_sum),
    .in_valid  (in_valid),
    .opx0      (opx0),
    .opy0      (opy0),
    .coef_use0 (coef_use0),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/dmul_slice_tb_top.sv
`timescale 1ns/1ps
module dmul_slice_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 0, cfg_sum = 0, cfg_sub = 0, in_valid = 0;
    logic [26:0] opx0 = '0, opy0 = '0;
    logic [17:0] opx1 = '0;
    logic [18:0] opy1 = '0;
    logic        coef_use0 = 0, coef_use1 = 0;
    logic [2:0]  coef_sel0 = '0, coef_sel1 = '0;
    logic        cw_en = 0, cw_bank = 0;
    logic [2:0]  cw_addr = '0;
    logic [26:0] cw_data = '0;
    logic        out_valid;
    logic [73:0] out_data;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    typedef struct {
        logic [73:0] data;
        int          due;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [26:0] sh0 [8];
    logic [17:0] sh1 [8];
    logic [73:0] last_data = '0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dmul_slice dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_sum(cfg_sum),
        .cfg_sub(cfg_sub), .in_valid(in_valid), .opx0(opx0), .opy0(opy0),
        .opx1(opx1), .opy1(opy1), .coef_use0(coef_use0), .coef_use1(coef_use1),
        .coef_sel0(coef_sel0), .coef_sel1(coef_sel1), .cw_en(cw_en),
        .cw_bank(cw_bank), .cw_addr(cw_addr), .cw_data(cw_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(string tag, logic [73:0] got, logic [73:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [73:0] model();
        logic [26:0] xe0;
        logic [17:0] xe1;
        longint p0, p1, pw, s;
        xe0 = coef_use0 ? sh0[coef_sel0] : opx0;
        xe1 = coef_use1 ? sh1[coef_sel1] : opx1;
        if (cfg_wide) begin
            pw = longint'($signed(xe0)) * longint'($signed(opy0));
            return {{10{pw[63]}}, pw};
        end
        p0 = longint'($signed(xe0[17:0])) * longint'($signed(opy0[18:0]));
        p1 = longint'($signed(xe1)) * longint'($signed(opy1));
        if (!cfg_sum) return {p1[36:0], p0[36:0]};
        s = cfg_sub ? p0 - p1 : p0 + p1;
        return {{10{s[63]}}, s};
    endfunction

    // called right after a falling edge with inputs already set
    task automatic step(string tag);
        exp_t e;
        if (in_valid) begin
            e.data = model();
            e.due  = cyc + 2;
            e.tag  = tag;
            sb.push_back(e);
        end
        if (cw_en) begin
            if (cw_bank) sh1[cw_addr] = cw_data[17:0];
            else         sh0[cw_addr] = cw_data;
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 0;
        cw_en    = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step("idle");
    endtask

    task automatic wr(bit bank, logic [2:0] addr, logic [26:0] data);
        cw_en = 1; cw_bank = bank; cw_addr = addr; cw_data = data;
        step("write");
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R8: unexpected valid, got %h expected none", out_data);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(e.tag, out_data, e.data);
                    chk({e.tag, " R8 latency"}, 74'(cyc), 74'(e.due));
                end
                last_data = out_data;
            end else begin
                if (sb.size() != 0 && sb[0].due <= cyc) begin
                    checks++; fails++;
                    $display("FAIL R8: missing valid at cycle %0d, got 0 expected 1", cyc);
                    void'(sb.pop_front());
                end
                chk("R11 hold", out_data, last_data);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin sh0[i] = '0; sh1[i] = '0; end
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 74'(out_valid), 74'(0));
        chk("R1 reset data", out_data, '0);
        rst_n = 1;
        @(negedge clk);

        // R1: untouched coefficient entries read as zero
        in_valid = 1; coef_use0 = 1; coef_use1 = 1; coef_sel0 = 5; coef_sel1 = 2;
        opy0 = 27'd7; opy1 = 19'd9; step("R1 coef zero");
        coef_use0 = 0; coef_use1 = 0;
        idle(3);

        // R2: separate narrow products, including extremes
        in_valid = 1; opx0 = 27'h0020000; opy0 = 27'h0040000;
        opx1 = 18'h20000; opy1 = 19'h40000; step("R2 most negative");
        in_valid = 1; opx0 = 27'h001FFFF; opy0 = 27'h0040000;
        opx1 = 18'h1FFFF; opy1 = 19'h3FFFF; step("R2 mixed sign");
        for (int i = 0; i < 10; i++) begin
            in_valid = 1; opx0 = 27'($urandom); opy0 = 27'($urandom);
            opx1 = 18'($urandom); opy1 = 19'($urandom); step("R2 split");
        end
        idle(4);

        // R4 / R5: combined products
        cfg_sum = 1;
        in_valid = 1; opx0 = 27'h0020000; opy0 = 27'h0040000;
        opx1 = 18'h20000; opy1 = 19'h40000; step("R4 sum extreme");
        for (int i = 0; i < 6; i++) begin
            in_valid = 1; opx0 = 27'($urandom); opy0 = 27'($urandom);
            opx1 = 18'($urandom); opy1 = 19'($urandom); step("R4 sum");
        end
        cfg_sub = 1;
        in_valid = 1; opx0 = 27'h0020000; opy0 = 27'h003FFFF;
        opx1 = 18'h20000; opy1 = 19'h40000; step("R5 diff extreme");
        for (int i = 0; i < 6; i++) begin
            in_valid = 1; opx0 = 27'($urandom); opy0 = 27'($urandom);
            opx1 = 18'($urandom); opy1 = 19'($urandom); step("R5 diff");
        end
        cfg_sum = 0; cfg_sub = 0;
        idle(3);

        // R12: bank writes keep to their entry and width
        wr(1, 3, 27'h7FE0005);
        wr(0, 4, 27'h4000001);
        for (int k = 2; k < 6; k++) begin
            in_valid = 1; coef_use0 = 1; coef_use1 = 1;
            coef_sel0 = 3'(k); coef_sel1 = 3'(k);
            opy0 = 27'd1; opy1 = 19'd1; step("R12 entry isolation");
        end
        idle(3);

        // R6: load several taps, use them in narrow mode
        for (int k = 0; k < 8; k++) begin
            wr(0, 3'(k), 27'($urandom));
            wr(1, 3'(k), 27'($urandom));
        end
        for (int i = 0; i < 8; i++) begin
            in_valid = 1; coef_use0 = 1; coef_use1 = (i % 2) == 0;
            coef_sel0 = 3'(i); coef_sel1 = 3'(7 - i);
            opx0 = 27'($urandom); opy0 = 27'($urandom);
            opx1 = 18'($urandom); opy1 = 19'($urandom); step("R6 R10 coef per cycle");
        end
        coef_use1 = 0;
        idle(3);

        // R9: write and select the same entry in one cycle, then the next
        wr(0, 6, 27'h0000011);
        in_valid = 1; coef_use0 = 1; coef_sel0 = 6; opy0 = 27'd3;
        cw_en = 1; cw_bank = 0; cw_addr = 6; cw_data = 27'h0000022;
        step("R9 same cycle old value");
        in_valid = 1; coef_use0 = 1; coef_sel0 = 6; opy0 = 27'd3;
        step("R9 next cycle new value");
        coef_use0 = 0;
        idle(3);

        // R3 / R7: wide mode
        cfg_wide = 1;
        in_valid = 1; opx0 = 27'h4000000; opy0 = 27'h4000000; step("R3 wide most negative");
        in_valid = 1; opx0 = 27'h3FFFFFF; opy0 = 27'h4000000; step("R3 wide mixed sign");
        for (int i = 0; i < 6; i++) begin
            in_valid = 1; opx0 = 27'($urandom); opy0 = 27'($urandom); step("R3 wide");
        end
        wr(0, 1, 27'h5A5A5A5);
        for (int i = 0; i < 4; i++) begin
            in_valid = 1; coef_use0 = 1; coef_sel0 = 3'(i);
            opy0 = 27'($urandom); step("R7 wide coef");
        end
        coef_use0 = 0;
        idle(5);

        chk("R8 scoreboard drained", 74'(sb.size()), 74'(0));
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule